// File: doc/BRIEF.md
# Difference-Coefficient FIR Filter

This block is a four-tap FIR filter for streams of unsigned pixels, processed one image row at a time. Tap 0 multiplies the newest sample by its coefficient in the ordinary way. Every later tap multiplies its delayed sample only by the difference between its own coefficient and the one before it. It then adds the product that the previous tap formed for the same sample one accepted sample earlier. That earlier product is kept in a per-tap register. As a result, each tap still delivers the full coefficient-times-sample product. The products are then summed at full precision.

Because the reused products and the sample delay line carry history, a row boundary must be marked by a flush. The flush zeroes all of that state before the next row starts. The first outputs of a row are therefore those of a filter whose history is zero. Each flush costs one idle input cycle that a direct-form filter would not need.

A sample is accepted on any cycle with the valid input high and flush low. Its filtered result appears, registered, one cycle later.

Top module: `dcm_fir`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` is 0 and `out_data` is 0 until the first sample is accepted.
- R2: A sample is accepted on a rising edge where `in_valid` is 1 and `flush` is 0. `out_valid` is 1 for exactly the following cycle.
- R3: For the j-th sample accepted since the last flush (j counted from 0), `out_data` equals the sum over k = 0..3 of C_k·x[j−k], with x[i] = 0 for i < 0. It is the same value a direct-form FIR gives.
- R4: Coefficient k is the two's-complement field `COEFS[k*COEF_W +: COEF_W]`, so tap 0 sits in the least significant field. Samples are unsigned. `out_data` is two's complement.
- R5: A cycle with `flush` at 1 zeroes the sample delay line and every stored reused product. The next row's outputs then match a zero-padded row.
- R6: A sample presented together with `flush` is discarded. `out_valid` stays 0 in the next cycle, and the sample never appears in later outputs.
- R7: On a cycle with no accepted sample, `out_valid` is 0 in the next cycle and `out_data` keeps its previous value.
- R8: Idle cycles between samples do not shift the delay line. Outputs depend only on the sequence of accepted samples.
- R9: No overflow or clipping occurs for any sample values and any coefficients, including −512, 511 and adjacent pairs whose difference needs 11 bits.
- R10: Each tap's rebuilt product, difference product plus reused product, equals its coefficient times its delayed sample at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A sample is presented on `in_data` |
| in_data | input | SAMPLE_W (8) | Unsigned input sample |
| flush | input | 1 | Row boundary: clears history, discards any sample presented |
| out_valid | output | 1 | `out_data` holds a new filtered result |
| out_data | output | OUT_W (22) | Signed filtered result |

## Verification
A wrong reused product in tap k shows up at `out_data` on the next accepted sample, since the product enters the sum at once. The error remains until the sample it belongs to leaves the line, at most three further samples later. A flush that fails to clear state shows on the first outputs of the following row. Those outputs are compared against a zero-padded direct-form sum. Ramps, saturated rows and alternating rows give each tap different difference products to rebuild. Idle gaps and flushes that arrive together with a sample check that history moves only on accepted samples.

// File: rtl/dcm_fir_pkg.sv
package dcm_fir_pkg;

  // Per-cycle action on the stored history.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2
  } dcm_act_e;

endpackage

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_fir_pkg::*;
(
  input  logic     in_valid,
  input  logic     flush,
  output dcm_act_e act
);

  // Flush wins over a sample presented in the same cycle.
  always_comb begin
    if (flush)         act = ACT_CLEAR;
    else if (in_valid) act = ACT_LOAD;
    else               act = ACT_IDLE;
  end

endmodule

// File: rtl/dcm_delay.sv
module dcm_delay
  import dcm_fir_pkg::*;
#(
  parameter int NTAPS    = 4,
  parameter int SAMPLE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dcm_act_e                          act,
  input  logic [SAMPLE_W-1:0]               smp_new,
  output logic [NTAPS-1:0][SAMPLE_W-1:0]    line
);

  localparam int NREG = NTAPS - 1;

  logic [NREG-1:0][SAMPLE_W-1:0] line_q, line_d;

  always_comb begin
    line_d = line_q;
    case (act)
      ACT_LOAD: begin
        line_d[0] = smp_new;
        for (int k = 1; k < NREG; k++) line_d[k] = line_q[k-1];
      end
      ACT_CLEAR: line_d = '0;
      default:   line_d = line_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign line[0] = smp_new;
  for (genvar k = 1; k < NTAPS; k++) begin : g_line
    assign line[k] = line_q[k-1];
  end

  // R8: history only moves on an accepted sample
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IDLE) |=> $stable(line_q));

  // R5: flush empties the line
  p_line_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLEAR) |=> (line_q == '0));

endmodule

// File: rtl/dcm_tap.sv
module dcm_tap
  import dcm_fir_pkg::*;
#(
  parameter int                      SAMPLE_W = 8,
  parameter int                      COEF_W   = 10,
  parameter int                      PROD_W   = 20,
  parameter logic signed [COEF_W-1:0] COEF    = '0,
  parameter logic signed [COEF_W:0]   DCOEF   = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dcm_act_e                   act,
  input  logic [SAMPLE_W-1:0]        smp,
  input  logic signed [PROD_W-1:0]   prod_up,
  output logic signed [PROD_W-1:0]   prod_out
);

  logic signed [PROD_W-1:0] reuse_q, reuse_d;
  logic signed [PROD_W-1:0] smp_s, dcoef_s, dprod;

  // Capture the upstream full product; it belongs to the sample this tap sees next.
  always_comb begin
    case (act)
      ACT_LOAD:  reuse_d = prod_up;
      ACT_CLEAR: reuse_d = '0;
      default:   reuse_d = reuse_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reuse_q <= '0;
    else        reuse_q <= reuse_d;
  end

  assign smp_s    = PROD_W'($signed({1'b0, smp}));
  assign dcoef_s  = PROD_W'(DCOEF);
  assign dprod    = smp_s * dcoef_s;
  assign prod_out = dprod + reuse_q;

  // R10: difference product plus reused product rebuilds the full product
  p_rebuild_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prod_out == smp_s * PROD_W'(COEF));

  // R5: flush zeroes the reused product
  p_reuse_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLEAR) |=> (reuse_q == '0));

endmodule

// File: rtl/dcm_sum.sv
module dcm_sum #(
  parameter int NTAPS  = 4,
  parameter int PROD_W = 20,
  parameter int OUT_W  = 22
) (
  input  logic [NTAPS-1:0][PROD_W-1:0] prods,
  output logic signed [OUT_W-1:0]      total
);

  always_comb begin
    total = '0;
    for (int k = 0; k < NTAPS; k++)
      total = total + OUT_W'($signed(prods[k]));
  end

endmodule

// File: rtl/dcm_fir.sv
module dcm_fir
  import dcm_fir_pkg::*;
#(
  parameter int                          NTAPS    = 4,
  parameter int                          SAMPLE_W = 8,
  parameter int                          COEF_W   = 10,
  parameter logic [NTAPS*COEF_W-1:0]     COEFS    = {10'h3F9, 10'd300, 10'h200, 10'd511},
  parameter int                          OUT_W    = COEF_W + SAMPLE_W + 2 + $clog2(NTAPS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [SAMPLE_W-1:0]       in_data,
  input  logic                      flush,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   out_data
);

  localparam int PROD_W = COEF_W + SAMPLE_W + 2;

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dcm_act_e act;

  dcm_ctrl i_ctrl (
    .in_valid (in_valid),
    .flush    (flush),
    .act      (act)
  );

  logic [NTAPS-1:0][SAMPLE_W-1:0] line;

  dcm_delay #(.NTAPS(NTAPS), .SAMPLE_W(SAMPLE_W)) i_delay (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .act     (act),
    .smp_new (in_data),
    .line    (line)
  );

  logic [NTAPS-1:0][PROD_W-1:0] prods;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam logic signed [COEF_W-1:0] CK = COEFS[k*COEF_W +: COEF_W];
    if (k == 0) begin : g_head
      // Tap 0 uses its coefficient directly.
      assign prods[0] = PROD_W'($signed({1'b0, line[0]})) * PROD_W'(CK);
    end else begin : g_diff
      localparam logic signed [COEF_W-1:0] CP = COEFS[(k-1)*COEF_W +: COEF_W];
      localparam logic signed [COEF_W:0]   DK = (COEF_W+1)'(CK) - (COEF_W+1)'(CP);
      logic signed [PROD_W-1:0] p_out;
      dcm_tap #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .PROD_W   (PROD_W),
        .COEF     (CK),
        .DCOEF    (DK)
      ) i_tap (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .act      (act),
        .smp      (line[k]),
        .prod_up  ($signed(prods[k-1])),
        .prod_out (p_out)
      );
      assign prods[k] = p_out;
    end
  end

  logic signed [OUT_W-1:0] total;

  dcm_sum #(.NTAPS(NTAPS), .PROD_W(PROD_W), .OUT_W(OUT_W)) i_sum (
    .prods (prods),
    .total (total)
  );

  // Output stage: next-state and register kept apart, load on accept.
  logic                    vld_d;
  logic signed [OUT_W-1:0] dat_d;

  always_comb begin
    vld_d = (act == ACT_LOAD);
    dat_d = (act == ACT_LOAD) ? total : out_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= dat_d;
    end
  end

  // R2: accepted sample gives a valid result next cycle
  p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !flush) |=> out_valid);

  // R6: a sample alongside flush yields no result
  p_flush_drop_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> !out_valid);

  // R7: no accept, result held
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(in_valid && !flush) |=> (!out_valid && $stable(out_data)));

endmodule

// File: tb/test_dcm_fir.sv
module test_dcm_fir;

  localparam int NT = 4;
  localparam int SW = 8;
  localparam int CW = 10;
  localparam logic [NT*CW-1:0] K = {10'h3F9, 10'd300, 10'h200, 10'd511};
  localparam int OW = CW + SW + 2 + $clog2(NT);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [SW-1:0] in_data;
  logic          flush;
  logic          out_valid;
  logic [OW-1:0] out_data;

  always #2.5 clk = ~clk;

  dcm_fir #(.NTAPS(NT), .SAMPLE_W(SW), .COEF_W(CW), .COEFS(K)) i_dcm_fir (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .flush     (flush),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int checks = 0;
  int errors = 0;
  int row [0:255];
  int rlen = 0;
  int last_y = 0;
  bit done = 0;

  function automatic int coef(int k);
    return int'($signed(K[k*CW +: CW]));
  endfunction

  // Direct-form reference with zero padding before the row (R3, R4).
  function automatic int ref_y(int j);
    int s = 0;
    for (int k = 0; k < NT; k++)
      if (j - k >= 0) s += coef(k) * row[j-k];
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(int x, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = SW'(x);
    row[rlen] = x;
    rlen++;
    @(posedge clk); #1;
    last_y = ref_y(rlen - 1);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " data"}, int'($signed(out_data)), last_y);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      chk("R7 idle valid", int'(out_valid), 0);
      chk("R7 idle hold", int'($signed(out_data)), last_y);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    in_valid = 1'b0;
    flush    = 1'b1;
    @(posedge clk); #1;
    chk("R6 flush no valid", int'(out_valid), 0);
    @(negedge clk);
    flush = 1'b0;
    rlen  = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; flush = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset data", int'($signed(out_data)), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 post-reset valid", int'(out_valid), 0);
    chk("R1 post-reset data", int'($signed(out_data)), 0);
  endtask

  // R3 R4 R10: ramp row, back to back
  task automatic t_ramp();
    do_flush();
    for (int i = 0; i < 10; i++) push((i * 17 + 3) % 256, "R3 R4 R10 ramp");
  endtask

  // R9: saturated samples with extreme coefficients
  task automatic t_extreme();
    do_flush();
    for (int i = 0; i < 6; i++) push(255, "R9 extreme");
  endtask

  // R3: alternating full-scale pattern
  task automatic t_alt();
    do_flush();
    for (int i = 0; i < 8; i++) push((i % 2) ? 255 : 0, "R3 alternate");
  endtask

  // R7 R8: gaps between samples must not shift history
  task automatic t_gaps();
    int v;
    do_flush();
    v = 91;
    for (int i = 0; i < 7; i++) begin
      v = (v * 73 + 41) % 256;
      push(v, "R8 gapped");
      idle(i % 3 + 1);
    end
  endtask

  // R5: new row after flush sees zero history
  task automatic t_row_restart();
    do_flush();
    for (int i = 0; i < 5; i++) push(200 - i, "R5 row A");
    do_flush();
    push(77, "R5 row B first");
    chk("R5 first equals tap0 only", int'($signed(out_data)), coef(0) * 77);
    push(13, "R5 row B second");
    push(250, "R5 row B third");
  endtask

  // R6: sample presented with flush is discarded
  task automatic t_discard();
    do_flush();
    push(40, "R6 setup");
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'd200; flush = 1'b1;
    @(posedge clk); #1;
    chk("R6 discard no valid", int'(out_valid), 0);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    rlen = 0;
    push(9, "R6 after discard");
    chk("R6 no trace of dropped", int'($signed(out_data)), coef(0) * 9);
    push(5, "R6 second after discard");
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_extreme();
    t_alt();
    t_gaps();
    t_row_restart();
    t_discard();
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule